// File: doc/BRIEF.md
# Cascaded Fall-Through FIFO Chain

The block is a deep first-in first-out buffer built by placing several small fall-through buffer stages in series. Each stage shows its oldest word at its output as soon as it holds one, without any read request. Its valid indication is the write request of the next stage, and the next stage's space indication is its read request. There is no logic between the stages. A word written into an empty chain therefore moves forward one stage per clock until it reaches the final output. All stages share a single free-running clock. The usable depth is the sum of the stage depths.

Upstream logic writes a word by raising `wrEn` while `inReady` is high. Downstream logic sees `outValid` and the head word on `dataOut`, and takes it by raising `rdEn`. Because each stage hop is a registered handshake, the chain is easy to time, whatever its length. The cost is a fall-through latency of one clock per stage.

Top module: `fwft_chain`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, `outValid` is 0 and `inReady` is 1.
- R2: A word is accepted on a rising edge only when `wrEn` and `inReady` are both 1. A write attempted while `inReady` is 0 stores nothing, and no such word ever appears at `dataOut`.
- R3: The first word written into an empty chain, with `rdEn` held at 0, makes `outValid` rise after exactly STAGES rising edges, counting the accepting edge. That word is then on `dataOut`.
- R4: Words leave the chain in the order they were accepted, with none lost and none duplicated, under any pattern of `wrEn` and `rdEn`.
- R5: With no reads, the chain accepts exactly STAGES*STAGE_DEPTH words before `inReady` goes to 0. It never holds more than that.
- R6: A word is removed on a rising edge only when `rdEn` and `outValid` are both 1. `rdEn` while `outValid` is 0 has no effect. While `outValid` is 1 and `rdEn` is 0, `dataOut` and `outValid` hold.
- R7: An internal stage hands its head word to the next stage only when it holds a word and the next stage has room. Otherwise it keeps the word.
- R8: When one word is read from a full chain and nothing else happens, `inReady` returns to 1 after exactly STAGES rising edges, counting the reading edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared free-running clock of all stages |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request for the word on `dataIn` |
| dataIn | input | WIDTH | Word to be written |
| inReady | output | 1 | First stage has room for a word |
| dataOut | output | WIDTH | Head word of the last stage |
| outValid | output | 1 | Last stage holds a word |
| rdEn | input | 1 | Read request; removes the head word |

## Verification
The bench times the fall-through of a single word from an empty chain and the backward travel of one free slot from a full chain. A design whose stage latency is wrong, or which bypasses or double-registers a hop, would miss the exact edge on which each is expected. It fills the chain with no reads and keeps writing past full. A chain that reports full early, or that overwrites a stage, would show a wrong accepted count or a foreign word on the way out. Reads of an empty chain, and long runs of random enable densities, are scored against a queue model. A stage that drops a word during a stalled handshake, or repeats a word on a simultaneous push and pop, would show up as a mismatch in order or count.

// File: rtl/fwft_chain_pkg.sv
package fwft_chain_pkg;

  // Strobes from a stage controller to its storage.
  typedef struct packed {
    logic push;  // store dataIn at the write pointer and advance it
    logic pop;   // advance the read pointer past the head word
  } stageStrobe_t;

endpackage

// File: rtl/fwft_stage_ctrl.sv
module fwft_stage_ctrl
  import fwft_chain_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrReq,
  input  logic         rdReq,
  output logic         inReady,
  output logic         outValid,
  output stageStrobe_t strobe
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] fillCount;

  assign inReady  = (fillCount != FULL_CNT);
  assign outValid = (fillCount != '0);

  always_comb begin
    strobe.push = wrReq && inReady;
    strobe.pop  = rdReq && outValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= '0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10:   fillCount <= fillCount + CNT_W'(1);
        2'b01:   fillCount <= fillCount - CNT_W'(1);
        default: fillCount <= fillCount;
      endcase
    end
  end

endmodule

// File: rtl/fwft_stage_data.sv
module fwft_stage_data
  import fwft_chain_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  stageStrobe_t     strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= dataIn;
  end

  // Fall-through: the head word is visible without a read request.
  assign dataOut = store[rdPtr];

endmodule

// File: rtl/fwft_chain.sv
module fwft_chain
  import fwft_chain_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int STAGES      = 3,
  parameter int STAGE_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] dataIn,
  output logic             inReady,
  output logic [WIDTH-1:0] dataOut,
  output logic             outValid,
  input  logic             rdEn
);

  localparam int CAPACITY = STAGES * STAGE_DEPTH;

  logic [STAGES-1:0] stageValid;
  logic [STAGES-1:0] stageReady;
  logic [STAGES-1:0] stageWrReq;
  logic [STAGES-1:0] stageRdReq;
  logic [WIDTH-1:0]  stageDin  [STAGES];
  logic [WIDTH-1:0]  stageDout [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    stageStrobe_t strobe;

    if (i == 0) begin : g_head
      assign stageWrReq[i] = wrEn;
      assign stageDin[i]   = dataIn;
    end else begin : g_link
      assign stageWrReq[i] = stageValid[i-1];
      assign stageDin[i]   = stageDout[i-1];
    end

    if (i == STAGES - 1) begin : g_tail
      assign stageRdReq[i] = rdEn;
    end else begin : g_back
      assign stageRdReq[i] = stageReady[i+1];
    end

    fwft_stage_ctrl #(
      .DEPTH (STAGE_DEPTH)
    ) u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .wrReq    (stageWrReq[i]),
      .rdReq    (stageRdReq[i]),
      .inReady  (stageReady[i]),
      .outValid (stageValid[i]),
      .strobe   (strobe)
    );

    fwft_stage_data #(
      .WIDTH (WIDTH),
      .DEPTH (STAGE_DEPTH)
    ) u_data (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (strobe),
      .dataIn  (stageDin[i]),
      .dataOut (stageDout[i])
    );
  end

  assign inReady  = stageReady[0];
  assign outValid = stageValid[STAGES-1];
  assign dataOut  = stageDout[STAGES-1];

endmodule

// File: rtl/fwft_chain_checker.sv
module fwft_chain_checker #(
  parameter int WIDTH    = 16,
  parameter int STAGES   = 3,
  parameter int CAPACITY = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic             inReady,
  input logic             outValid,
  input logic [WIDTH-1:0] dataOut,
  input logic [STAGES-1:0] stageValid,
  input logic [STAGES-1:0] stageReady
);

  localparam int OCC_W = $clog2(CAPACITY + 1);
  localparam logic [OCC_W-1:0] CAP_OCC = OCC_W'(CAPACITY);

  logic [OCC_W-1:0] occupancy;
  logic             accepted;
  logic             removed;

  assign accepted = wrEn && inReady;
  assign removed  = rdEn && outValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occupancy <= '0;
    end else if (accepted && !removed) begin
      occupancy <= occupancy + OCC_W'(1);
    end else if (removed && !accepted) begin
      occupancy <= occupancy - OCC_W'(1);
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && inReady));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy == CAP_OCC) |-> !inReady);

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy == '0) |-> !outValid);

  assert_head_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !rdEn) |=> (outValid && $stable(dataOut)));

  for (genvar i = 0; i + 1 < STAGES; i++) begin : g_hold
    assert_stage_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      (stageValid[i] && !stageReady[i+1]) |=> stageValid[i]);
  end

endmodule

bind fwft_chain fwft_chain_checker #(
  .WIDTH    (WIDTH),
  .STAGES   (STAGES),
  .CAPACITY (CAPACITY)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .inReady    (inReady),
  .outValid   (outValid),
  .dataOut    (dataOut),
  .stageValid (stageValid),
  .stageReady (stageReady)
);

// File: tb/fwft_chain_bench.sv
`timescale 1ns/1ps
module fwft_chain_bench;

  localparam int WIDTH  = 16;
  localparam int STAGES = 3;
  localparam int SDEPTH = 4;
  localparam int CAP    = STAGES * SDEPTH;

  // Stimulus table: cycles, write density %, read density %.
  localparam int NPH = 6;
  localparam int PH_CYC [NPH] = '{400, 400, 400, 300, 300, 600};
  localparam int PH_WR  [NPH] = '{90,  30,  100, 50,  10,  70};
  localparam int PH_RD  [NPH] = '{30,  90,  100, 50,  100, 70};

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic             rdEn = 1'b0;
  logic [WIDTH-1:0] dataIn = '0;
  logic             inReady;
  logic             outValid;
  logic [WIDTH-1:0] dataOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [WIDTH-1:0] model [$];
  logic [WIDTH-1:0] nextWord = 16'h0100;

  always #5 clk = ~clk;

  fwft_chain #(.WIDTH(WIDTH), .STAGES(STAGES), .STAGE_DEPTH(SDEPTH)) u_fwft_chain (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .dataIn(dataIn), .inReady(inReady),
    .dataOut(dataOut), .outValid(outValid), .rdEn(rdEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; covers one rising edge; returns at a falling edge.
  task automatic cycle(input logic w, input logic r, input string req);
    logic [WIDTH-1:0] d;
    d = nextWord;
    if (r && outValid) begin
      check(model.size() > 0 && dataOut == model[0], req, int'(dataOut),
            model.size() > 0 ? int'(model[0]) : -1);
      if (model.size() > 0) void'(model.pop_front());
    end
    if (w && inReady) begin
      model.push_back(d);
      nextWord = nextWord + 16'd1;
    end
    wrEn = w; rdEn = r; dataIn = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    wrEn = 1'b0; rdEn = 1'b0;
    rstN = 1'b0;
    model.delete();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 4 * CAP && model.size() > 0; k++) cycle(1'b0, 1'b1, req);
    cycle(1'b0, 1'b0, req);
    check(model.size() == 0, req, model.size(), 0);
    check(outValid == 1'b0, req, int'(outValid), 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    doReset();
    check(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    check(inReady == 1'b1, "R1 inReady", int'(inReady), 1);

    // R3: fall-through latency of one word
    begin
      logic [WIDTH-1:0] first;
      first = nextWord;
      cycle(1'b1, 1'b0, "R3");
      for (int k = 0; k < STAGES - 2; k++) cycle(1'b0, 1'b0, "R3");
      check(outValid == 1'b0, "R3 early", int'(outValid), 0);
      cycle(1'b0, 1'b0, "R3");
      check(outValid == 1'b1, "R3 arrive", int'(outValid), 1);
      check(dataOut == first, "R3 data", int'(dataOut), int'(first));
    end
    drain("R4 after R3");

    // R6: reads of an empty chain are ignored
    doReset();
    for (int k = 0; k < 3; k++) cycle(1'b0, 1'b1, "R6");
    check(outValid == 1'b0, "R6 empty read", int'(outValid), 0);
    check(inReady == 1'b1, "R6 empty read ready", int'(inReady), 1);
    cycle(1'b1, 1'b1, "R6");
    for (int k = 0; k < STAGES; k++) cycle(1'b0, 1'b0, "R6");
    check(model.size() == 1 && outValid, "R6 word kept", int'(outValid), 1);
    drain("R6 drain");

    // R5 / R2: fill with no reads, keep writing past full
    doReset();
    for (int k = 0; k < 3 * CAP; k++) cycle(1'b1, 1'b0, "R5");
    check(model.size() == CAP, "R5 capacity", model.size(), CAP);
    check(inReady == 1'b0, "R5 full", int'(inReady), 0);

    // R8: one read from full; slot returns to input after STAGES edges
    cycle(1'b0, 1'b1, "R8");
    for (int k = 0; k < STAGES - 2; k++) cycle(1'b0, 1'b0, "R8");
    check(inReady == 1'b0, "R8 early", int'(inReady), 0);
    cycle(1'b0, 1'b0, "R8");
    check(inReady == 1'b1, "R8 slot", int'(inReady), 1);
    drain("R2 ignored writes");

    // R4 / R7: random enable densities from the table
    doReset();
    for (int p = 0; p < NPH; p++) begin
      for (int c = 0; c < PH_CYC[p]; c++) begin
        cycle(($urandom % 100) < PH_WR[p], ($urandom % 100) < PH_RD[p], "R4 R7 random");
      end
    end
    drain("R4 final");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule